// File: doc/BRIEF.md
# Programmable-Timing External Memory Bus Controller

This block connects a single-request internal port to an asynchronous SRAM-style device on a shared address/data bus. A request carries a byte address, a read/write flag, a halfword of write data and two byte enables. The controller puts the address on the shared lines under an address-latch strobe. It then pulses an active-low read or write strobe, and returns the read data together with a one-cycle done pulse.

The external address range is split into four 128 KB regions, chosen by the top two address bits. Each region has its own chip select, an enable, a width select (8-bit or 16-bit) and a timing word. The timing word stretches the address-latch phase and the read and write strobes by separate amounts. It can also add a hold cycle after the strobe and a turn-around cycle after a read. A global enable must be set before any bus cycle is issued. A configuration write port loads the global, control and timing registers.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset the bus is quiet: latch strobe low, both strobes high, all chip selects high, data output enable low, `req_ready` high, `rsp_done` low.
- R2: The global enable is bit 0 of configuration address 0x0. While it is clear, an accepted request produces `rsp_done` and `rsp_err` in the next cycle, with no chip select, strobe or latch activity.
- R3: The region is `req_addr[18:17]`. Its control register sits at configuration address 0x4+region, with bit 0 as the enable and bit 1 selecting 16-bit width. A request to a disabled region completes like R2 with an error. Only the decoded region's chip select is ever low.
- R4: The address phase holds the latch strobe high for 1 + timing[14:12] cycles, drives the cycle address on the shared lines (`bus_a_hi` carries bits 18:16) and holds the region's chip select low.
- R5: The read strobe stays low for 1 + timing[3:0] cycles and the write strobe for 1 + timing[7:4] cycles, never both at once. Read data is sampled on the last read-strobe cycle. Write data is driven throughout the write strobe.
- R6: When timing bit 8 is set, one hold cycle follows the strobe. In it both strobes are high, the chip select stays low and write data is still driven.
- R7: When timing bit 9 is set, every read is followed by one cycle with all chip selects high and the data lines released. Only then may done or a new address phase follow.
- R8: Each timing register resets to 0x70FF (configuration address 0x8+region), giving an 8-cycle latch phase, 16-cycle strobes, and no hold or turn-around cycle.
- R9: A 16-bit region makes one transfer per request. The address has bit 0 cleared, `bus_be_n` is the inverse of the byte enables, and bytes that are not enabled read as zero.
- R10: An 8-bit region makes one byte cycle per enabled byte, low byte first. The cycle address bit 0 selects the byte, and data travels on lines 7:0 with `bus_be_n` = 2'b10. Read bytes are assembled into their lanes.
- R11: A request with both byte enables clear completes in the next cycle with done, no error and no bus activity.
- R12: `req_ready` is low from the cycle after acceptance until the single done cycle, and `rsp_done` rises in the cycle after the last bus phase.
- R13: The controller never drives the data lines while the read strobe is low or during a turn-around cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_addr | input | 4 | Configuration address: [3:2] group (0 global, 1 control, 2 timing), [1:0] region |
| cfg_wdata | input | 16 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted at this edge |
| req_addr | input | 19 | Byte address; [18:17] picks the region |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write halfword |
| req_be | input | 2 | Byte enables (bit 0 low byte) |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request refused (valid with done) |
| rsp_rdata | output | 16 | Read data (valid with done) |
| bus_ale | output | 1 | Address latch strobe, high in address phase |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_cs_n | output | 4 | Active-low chip select per region |
| bus_be_n | output | 2 | Active-low byte lane enables |
| bus_ad_out | output | 16 | Shared address/data lines, outgoing value |
| bus_ad_oe | output | 1 | Drive enable for the shared lines |
| bus_ad_in | input | 16 | Shared address/data lines, incoming value |
| bus_a_hi | output | 3 | Upper address bits 18:16 |

## Verification
The bench goes after the phase lengths at both ends of each field: zero extends, the all-ones reset timing, and hold and turn-around switched on together. A counter that is off by one there would stretch or clip a strobe by a cycle. It also makes partial-byte accesses in 8-bit mode, where a design that ignored the byte enables would make a needless second cycle or put the byte in the wrong lane. It makes back-to-back requests after a read with turn-around, where a missing release cycle would put the next address onto a bus the device still drives. Requests to a disabled region and with the global enable clear must finish with an error and never touch the chip selects.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int HW = 16;
  localparam logic [15:0] TIMING_RST = 16'h70FF;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_STRB, S_HOLD, S_TURN} phase_t;

  typedef struct packed {
    logic [2:0] ale_ext;
    logic       turn_en;
    logic       hold_en;
    logic [3:0] wr_ext;
    logic [3:0] rd_ext;
  } tparm_t;

  function automatic tparm_t unpack_timing(input logic [15:0] w);
    tparm_t t;
    t.ale_ext = w[14:12];
    t.turn_en = w[9];
    t.hold_en = w[8];
    t.wr_ext  = w[7:4];
    t.rd_ext  = w[3:0];
    return t;
  endfunction
endpackage

// File: rtl/xbus_regs.sv
module xbus_regs
  import xbus_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_wr,
  input  logic [$clog2(NREG)+1:0]       cfg_addr,
  input  logic [15:0]                   cfg_wdata,
  output logic                          glb_en,
  output logic [NREG-1:0]               reg_en,
  output logic [NREG-1:0]               reg_wide,
  output logic [NREG-1:0][15:0]         reg_timing
);
  localparam int RIDX_W = $clog2(NREG);

  logic [1:0]        grp;
  logic [RIDX_W-1:0] idx;
  logic              wr_glb;

  assign grp    = cfg_addr[RIDX_W+1:RIDX_W];
  assign idx    = cfg_addr[RIDX_W-1:0];
  assign wr_glb = cfg_wr && (grp == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      glb_en <= 1'b0;
    else if (wr_glb) glb_en <= cfg_wdata[0];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_region
    logic wr_ctl, wr_tim;
    assign wr_ctl = cfg_wr && (grp == 2'd1) && (idx == RIDX_W'(g));
    assign wr_tim = cfg_wr && (grp == 2'd2) && (idx == RIDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_en[g]   <= 1'b0;
        reg_wide[g] <= 1'b0;
      end else if (wr_ctl) begin
        reg_en[g]   <= cfg_wdata[0];
        reg_wide[g] <= cfg_wdata[1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_timing[g] <= TIMING_RST;
      else if (wr_tim) reg_timing[g] <= cfg_wdata;
    end
  end
endmodule

// File: rtl/xbus_decode.sv
module xbus_decode
  import xbus_pkg::*;
#(
  parameter int NREG = 4,
  parameter int AW   = 19
) (
  input  logic [AW-1:0]           addr,
  input  logic                    glb_en,
  input  logic [NREG-1:0]         reg_en,
  input  logic [NREG-1:0]         reg_wide,
  input  logic [NREG-1:0][15:0]   reg_timing,
  output logic                    ok,
  output logic [$clog2(NREG)-1:0] idx,
  output logic                    wide,
  output tparm_t                  tp
);
  localparam int RIDX_W = $clog2(NREG);

  assign idx  = addr[AW-1 -: RIDX_W];
  assign ok   = glb_en && reg_en[idx];
  assign wide = reg_wide[idx];
  assign tp   = unpack_timing(reg_timing[idx]);
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int NREG = 4,
  parameter int AW   = 19
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [AW-1:0]           req_addr,
  input  logic                    req_wr,
  input  logic [HW-1:0]           req_wdata,
  input  logic [1:0]              req_be,
  input  logic                    dec_ok,
  input  logic [$clog2(NREG)-1:0] dec_idx,
  input  logic                    dec_wide,
  input  tparm_t                  dec_tp,
  output logic                    req_ready,
  output logic                    rsp_done,
  output logic                    rsp_err,
  output logic [HW-1:0]           rsp_rdata,
  output logic                    bus_ale,
  output logic                    bus_rd_n,
  output logic                    bus_wr_n,
  output logic [NREG-1:0]         bus_cs_n,
  output logic [1:0]              bus_be_n,
  output logic [HW-1:0]           bus_ad_out,
  output logic                    bus_ad_oe,
  input  logic [HW-1:0]           bus_ad_in,
  output logic [AW-HW-1:0]        bus_a_hi
);
  localparam int RIDX_W = $clog2(NREG);

  phase_t            phase, n_phase;
  logic [3:0]        cnt, n_cnt;
  logic [AW-1:0]     r_addr, n_addr;
  logic              r_wr, n_wr;
  logic [HW-1:0]     r_wdata, n_wdata, r_rdata, n_rdata;
  logic [1:0]        r_be, n_be;
  logic [RIDX_W-1:0] r_idx, n_idx;
  logic              r_wide, n_wide, r_hi, n_hi, r_more, n_more;
  tparm_t            r_tp, n_tp;
  logic              done_q, n_done, err_q, n_err, last;
  logic [AW-1:0]     cyc_addr;
  logic              active;

  always_comb begin
    n_phase = phase;   n_cnt   = cnt;     n_addr = r_addr;  n_wr   = r_wr;
    n_wdata = r_wdata; n_rdata = r_rdata; n_be   = r_be;    n_idx  = r_idx;
    n_wide  = r_wide;  n_tp    = r_tp;    n_hi   = r_hi;    n_more = r_more;
    n_done  = 1'b0;    n_err   = 1'b0;    last   = 1'b0;
    unique case (phase)
      S_IDLE: if (req_valid) begin
        n_addr = req_addr; n_wr = req_wr; n_wdata = req_wdata; n_be = req_be;
        n_idx  = dec_idx;  n_wide = dec_wide; n_tp = dec_tp; n_rdata = '0;
        if (!dec_ok) begin
          n_done = 1'b1;
          n_err  = 1'b1;
        end else if (req_be == 2'b00) begin
          n_done = 1'b1;
        end else begin
          n_phase = S_ADDR;
          n_cnt   = {1'b0, dec_tp.ale_ext};
          n_hi    = !dec_wide && !req_be[0];
          n_more  = !dec_wide && (&req_be);
        end
      end
      S_ADDR: if (cnt == 4'd0) begin
        n_phase = S_STRB;
        n_cnt   = r_wr ? r_tp.wr_ext : r_tp.rd_ext;
      end else n_cnt = cnt - 4'd1;
      S_STRB: if (cnt == 4'd0) begin
        if (!r_wr) begin
          if (r_wide)    n_rdata = bus_ad_in & {{8{r_be[1]}}, {8{r_be[0]}}};
          else if (r_hi) n_rdata[15:8] = bus_ad_in[7:0];
          else           n_rdata[7:0]  = bus_ad_in[7:0];
        end
        if (r_tp.hold_en)                n_phase = S_HOLD;
        else if (!r_wr && r_tp.turn_en)  n_phase = S_TURN;
        else                             last    = 1'b1;
      end else n_cnt = cnt - 4'd1;
      S_HOLD: if (!r_wr && r_tp.turn_en) n_phase = S_TURN;
              else                       last    = 1'b1;
      S_TURN: last = 1'b1;
      default: n_phase = S_IDLE;
    endcase
    if (last) begin
      if (r_more) begin
        n_more  = 1'b0;
        n_hi    = 1'b1;
        n_phase = S_ADDR;
        n_cnt   = {1'b0, r_tp.ale_ext};
      end else begin
        n_phase = S_IDLE;
        n_done  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= S_IDLE; cnt <= '0; r_addr <= '0; r_wr <= 1'b0; r_wdata <= '0;
      r_rdata <= '0; r_be <= '0; r_idx <= '0; r_wide <= 1'b0; r_tp <= '0;
      r_hi <= 1'b0; r_more <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      phase <= n_phase; cnt <= n_cnt; r_addr <= n_addr; r_wr <= n_wr;
      r_wdata <= n_wdata; r_rdata <= n_rdata; r_be <= n_be; r_idx <= n_idx;
      r_wide <= n_wide; r_tp <= n_tp; r_hi <= n_hi; r_more <= n_more;
      done_q <= n_done; err_q <= n_err;
    end
  end

  assign active     = (phase == S_ADDR) || (phase == S_STRB) || (phase == S_HOLD);
  assign cyc_addr   = {r_addr[AW-1:1], !r_wide && r_hi};
  assign req_ready  = (phase == S_IDLE);
  assign rsp_done   = done_q;
  assign rsp_err    = err_q;
  assign rsp_rdata  = r_rdata;
  assign bus_ale    = (phase == S_ADDR);
  assign bus_rd_n   = !((phase == S_STRB) && !r_wr);
  assign bus_wr_n   = !((phase == S_STRB) && r_wr);
  assign bus_cs_n   = active ? ~(NREG'(1) << r_idx) : '1;
  assign bus_be_n   = !active ? 2'b11 : (r_wide ? ~r_be : 2'b10);
  assign bus_ad_oe  = (phase == S_ADDR) || (r_wr && ((phase == S_STRB) || (phase == S_HOLD)));
  assign bus_a_hi   = cyc_addr[AW-1:HW];
  assign bus_ad_out = (phase == S_ADDR) ? cyc_addr[HW-1:0] :
                      r_wide ? r_wdata : {8'h00, (r_hi ? r_wdata[15:8] : r_wdata[7:0])};

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n)); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n)); // R5
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_ad_oe); // R13
  AST_ALE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (bus_rd_n && bus_wr_n && !bus_cs_n[r_idx])); // R4
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_done); // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs_n[r_idx] |-> !req_ready); // R12
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int NREG     = 4,
  parameter int RBYTES_W = 17,
  localparam int RIDX_W  = $clog2(NREG),
  localparam int AW      = RBYTES_W + RIDX_W,
  localparam int CFG_AW  = RIDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [15:0]       cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_wr,
  input  logic [HW-1:0]     req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [HW-1:0]     rsp_rdata,
  output logic              bus_ale,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [NREG-1:0]   bus_cs_n,
  output logic [1:0]        bus_be_n,
  output logic [HW-1:0]     bus_ad_out,
  output logic              bus_ad_oe,
  input  logic [HW-1:0]     bus_ad_in,
  output logic [AW-HW-1:0]  bus_a_hi
);
  logic [1:0]            rsync;
  logic                  rst_int_n;
  logic                  glb_en;
  logic [NREG-1:0]       reg_en, reg_wide;
  logic [NREG-1:0][15:0] reg_timing;
  logic                  dec_ok, dec_wide;
  logic [RIDX_W-1:0]     dec_idx;
  tparm_t                dec_tp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_int_n = rsync[1];

  xbus_regs #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .glb_en(glb_en), .reg_en(reg_en),
    .reg_wide(reg_wide), .reg_timing(reg_timing));

  xbus_decode #(.NREG(NREG), .AW(AW)) u_dec (
    .addr(req_addr), .glb_en(glb_en), .reg_en(reg_en), .reg_wide(reg_wide),
    .reg_timing(reg_timing), .ok(dec_ok), .idx(dec_idx), .wide(dec_wide),
    .tp(dec_tp));

  xbus_seq #(.NREG(NREG), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_wr(req_wr), .req_wdata(req_wdata), .req_be(req_be),
    .dec_ok(dec_ok), .dec_idx(dec_idx), .dec_wide(dec_wide), .dec_tp(dec_tp),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_cs_n(bus_cs_n), .bus_be_n(bus_be_n),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
    .bus_a_hi(bus_a_hi));

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && req_ready && !glb_en) |=> (&bus_cs_n && !bus_ale)); // R2
  AST_REGION_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && req_ready && !reg_en[dec_idx]) |=> (&bus_cs_n && rsp_err)); // R3
endmodule

// File: tb/xbus_ctrl_test.sv
`timescale 1ns/1ps
module xbus_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        req_valid = 1'b0, req_wr = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_done, rsp_err, bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe;
  logic [15:0] rsp_rdata, bus_ad_out, bus_ad_in;
  logic [3:0]  bus_cs_n;
  logic [1:0]  bus_be_n;
  logic [2:0]  bus_a_hi;
  logic [18:0] lat = '0;

  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  xbus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wr(req_wr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_cs_n(bus_cs_n), .bus_be_n(bus_be_n),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
    .bus_a_hi(bus_a_hi));

  function automatic logic [7:0] pat(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h3C;
  endfunction

  // device model: latch address under ALE, return a pattern per byte address
  always @(posedge clk) if (bus_ale) lat <= {bus_a_hi, bus_ad_out};
  assign bus_ad_in = {pat({lat[18:1], 1'b1}), pat(lat)};

  typedef struct {
    bit ale, rd_n, wr_n; bit [3:0] cs_n; bit oe; bit [15:0] ad; bit [2:0] ahi;
    bit [1:0] be_n; bit ready, done, err; bit [15:0] rdata; int rq;
  } exp_t;
  exp_t q[$];

  bit        m_glb = 0;
  bit [3:0]  m_en = 0, m_wide = 0;
  bit [15:0] m_tim [4] = '{16'h70FF, 16'h70FF, 16'h70FF, 16'h70FF};

  task automatic check(input bit ok, input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic push(input bit ale, rd_n, wr_n, input bit [3:0] cs_n, input bit oe,
                      input bit [15:0] ad, input bit [2:0] ahi, input bit [1:0] be_n,
                      input bit ready, done, err, input bit [15:0] rdata, input int rq);
    exp_t e;
    e.ale = ale; e.rd_n = rd_n; e.wr_n = wr_n; e.cs_n = cs_n; e.oe = oe; e.ad = ad;
    e.ahi = ahi; e.be_n = be_n; e.ready = ready; e.done = done; e.err = err;
    e.rdata = rdata; e.rq = rq;
    q.push_back(e);
  endtask

  task automatic tick;
    exp_t e;
    logic [11:0] a, x;
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else begin
      e.ale = 0; e.rd_n = 1; e.wr_n = 1; e.cs_n = 4'hF; e.oe = 0; e.ad = 0; e.ahi = 0;
      e.be_n = 2'b11; e.ready = 1; e.done = 0; e.err = 0; e.rdata = 0; e.rq = 1; // R1 idle
    end
    a = {bus_ale, bus_rd_n, bus_wr_n, bus_cs_n, bus_ad_oe, bus_be_n, req_ready, rsp_done};
    x = {e.ale, e.rd_n, e.wr_n, e.cs_n, e.oe, e.be_n, e.ready, e.done};
    check(a === x, e.rq, "ale/rd/wr/cs/oe/be/ready/done", 32'(a), 32'(x));
    if (e.oe) check(bus_ad_out === e.ad, e.rq, "ad_out", 32'(bus_ad_out), 32'(e.ad));
    if (e.ale) check(bus_a_hi === e.ahi, e.rq, "a_hi", 32'(bus_a_hi), 32'(e.ahi));
    if (e.done) check({rsp_err, rsp_rdata} === {e.err, e.rdata}, e.rq, "err/rdata",
                      32'({rsp_err, rsp_rdata}), 32'({e.err, e.rdata}));
  endtask

  task automatic cfg(input bit [1:0] grp, input bit [1:0] idx, input bit [15:0] d);
    cfg_wr = 1; cfg_addr = {grp, idx}; cfg_wdata = d;
    if (grp == 0) m_glb = d[0];
    if (grp == 1) begin m_en[idx] = d[0]; m_wide[idx] = d[1]; end
    if (grp == 2) m_tim[idx] = d;
    tick;
    cfg_wr = 0;
  endtask

  task automatic txn(input bit [18:0] addr, input bit wr, input bit [15:0] wd,
                     input bit [1:0] be, input int rq);
    int r = int'(addr[18:17]);
    bit [15:0] t = m_tim[r];
    bit [3:0] cs = ~(4'b1 << r);
    bit [15:0] rd = 0;
    req_valid = 1; req_addr = addr; req_wr = wr; req_wdata = wd; req_be = be;
    if (!(m_glb && m_en[r])) begin
      push(0, 1, 1, 4'hF, 0, 0, 0, 2'b11, 1, 1, 1, 16'h0, rq);
    end else if (be == 2'b00) begin
      push(0, 1, 1, 4'hF, 0, 0, 0, 2'b11, 1, 1, 0, 16'h0, rq);
    end else begin
      for (int b = 0; b < 2; b++) begin
        bit hi = bit'(b);
        bit [18:0] ca = {addr[18:1], m_wide[r] ? 1'b0 : hi};
        bit [1:0] ben = m_wide[r] ? ~be : 2'b10;
        bit [15:0] dl = m_wide[r] ? wd : {8'h00, hi ? wd[15:8] : wd[7:0]};
        if (m_wide[r] && b == 1) break;
        if (!m_wide[r] && !be[b]) continue;
        for (int i = 0; i <= int'(t[14:12]); i++)
          push(1, 1, 1, cs, 1, ca[15:0], ca[18:16], ben, 0, 0, 0, 0, rq);
        for (int i = 0; i <= int'(wr ? t[7:4] : t[3:0]); i++)
          push(0, wr, !wr, cs, wr, dl, 0, ben, 0, 0, 0, 0, rq);
        if (t[8]) push(0, 1, 1, cs, wr, dl, 0, ben, 0, 0, 0, 0, rq);
        if (!wr && t[9]) push(0, 1, 1, 4'hF, 0, 0, 0, 2'b11, 0, 0, 0, 0, rq);
      end
      if (!wr) rd = {be[1] ? pat({addr[18:1], 1'b1}) : 8'h00,
                     be[0] ? pat({addr[18:1], 1'b0}) : 8'h00};
      push(0, 1, 1, 4'hF, 0, 0, 0, 2'b11, 1, 1, 0, rd, rq);
    end
    tick;
    req_valid = 0;
    while (q.size() > 0) tick;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R12 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) tick;
    rst_n = 1;
    repeat (4) tick;                                   // R1 quiet after reset
    txn(19'h00010, 0, 0, 2'b11, 2);                    // R2 global enable clear
    cfg(0, 0, 16'h0001);
    txn(19'h00020, 0, 0, 2'b11, 3);                    // R3 region 0 disabled
    cfg(1, 0, 16'h0003);                               // region 0: on, 16-bit
    txn(19'h01234, 0, 0, 2'b11, 8);                    // R8 reset timing, read
    txn(19'h01236, 1, 16'hBEEF, 2'b11, 8);             // R8 reset timing, write
    cfg(2, 0, 16'h1332);                               // ale+1, wr+3, rd+2, hold, turn
    txn(19'h00100, 0, 0, 2'b11, 6);                    // R6 R7 read with hold and turn
    txn(19'h00102, 0, 0, 2'b11, 7);                    // R7 back-to-back after turn
    txn(19'h00104, 1, 16'hA55A, 2'b11, 5);             // R5 write with hold
    txn(19'h00107, 0, 0, 2'b01, 9);                    // R9 odd address, low lane only
    txn(19'h00108, 1, 16'h1234, 2'b10, 9);             // R9 high lane write
    cfg(2, 0, 16'h0000);
    txn(19'h00200, 0, 0, 2'b11, 4);                    // R4 zero extends
    txn(19'h00202, 1, 16'h0F0F, 2'b11, 4);             // R4 zero extends write
    cfg(1, 2, 16'h0001);                               // region 2: on, 8-bit
    cfg(2, 2, 16'h2210);                               // ale+2, turn, wr+1, rd+0
    txn(19'h40050, 0, 0, 2'b11, 10);                   // R10 two byte cycles, low first
    txn(19'h40052, 1, 16'hC3D4, 2'b11, 10);            // R10 write split
    txn(19'h40055, 0, 0, 2'b10, 10);                   // R10 high byte only
    txn(19'h40056, 1, 16'h7788, 2'b01, 10);            // R10 low byte only
    txn(19'h40058, 0, 0, 2'b00, 11);                   // R11 no bytes
    txn(19'h60000, 0, 0, 2'b11, 3);                    // R3 region 3 disabled
    txn(19'h20000, 1, 16'h1111, 2'b11, 3);             // R3 region 1 disabled
    cfg(0, 0, 16'h0000);
    txn(19'h00100, 0, 0, 2'b11, 2);                    // R2 global clear again
    cfg(0, 0, 16'h0001);
    cfg(2, 0, 16'h0F0F);                               // R13 long read strobe
    txn(19'h00300, 0, 0, 2'b11, 13);
    repeat (3) tick;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule